// File: doc/BRIEF.md
# Descriptor DMA Channel Register and Control Block

This block is the software-facing front of a multi-channel descriptor DMA controller. Each channel has its own register window on a simple word-only memory-mapped bus. The window holds descriptor and context pointers, configuration and command registers, and a small interrupt unit with raw, mask and write-one-to-clear acknowledge registers. Each channel also keeps a reset/stopped/running state in one-hot form and an end-of-list flag.

The transfer engine for each channel sits outside this block. The engine reads the descriptor that the channel's saved data pointer selects and returns that descriptor's end-of-list bit, next pointer and buffer pointer. It also returns the two saved-pointer words of the current context. The engine reports end-of-list events and interrupt causes back to the block. In return, the block sends single-cycle pulses that ask the engine to load a data descriptor, load a context, or start moving data. A command write can resume a chain that stalled at end of list, but only after software has cleared the end-of-list bit in the descriptor that stalled it.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset every channel is in the reset state (state code 1), its configuration reads 0, its raw interrupts and mask read 0, its interrupt line is low and no request pulse is high.
- R2: The channel index is the address bits from bit 13 upward, and the register index is address bits 7:2. Registers at 0x00, 0x58, 0x5C, 0x60, 0x7C, 0x80, 0x84, 0x8C and 0x9C read back the last value written. The acknowledge register 0x90 always reads 0. Writes to 0x88, 0x94, 0x98 and to unlisted offsets change nothing, and unlisted offsets read 0.
- R3: Every request gets a response one cycle later. An access with a size code other than 2 (word), or to a channel index at or above the channel count, returns an error with read data 0 and modifies nothing.
- R4: A write to the configuration register (0x84) with bit 1 set makes the state stopped (code 2). A write with bit 0 clear makes the state reset (code 1), and this rule takes precedence over the bit-1 rule. Any other configuration write leaves the state unchanged.
- R5: The status register (0x88) reads the state code in bits 2:0, the end-of-list flag in bit 5, and the channel's source-id input from bit 8 upward. All other bits read 0.
- R6: The raw interrupt register (0x94) accumulates the engine's cause pulses. Writing ones to the acknowledge register (0x90) clears those raw bits. A cause pulse that arrives in the same cycle as an acknowledge of the same bit wins, and the bit stays set.
- R7: The masked register (0x98) reads raw AND mask (0x8C), and the channel's interrupt line is the OR of the masked bits. Both follow a mask write, an acknowledge or a cause pulse by the next cycle.
- R8: A stream-command write (0x9C) with bit 8 or bit 6 set copies the saved data pointer into the data register (0x00) and pulses the load-descriptor request. If bit 5 is also set, the write pulses the start request, sets the state to running (code 4) and clears the end-of-list flag.
- R9: A stream-command write with bit 9 set copies the context's saved-data word into 0x58 and its saved-buffer word into 0x5C, and pulses the load-context request.
- R10: An end-of-list pulse from the engine sets the channel's end-of-list flag. The flag stays set until a start clears it.
- R11: A command write (0x80) does nothing beyond storing its value unless all of the following hold: configuration bit 0 is set, configuration bit 1 is clear, the state is running, and the last descriptor loaded had its end-of-list bit set.
- R12: A command write that meets the R11 conditions reloads the current descriptor and pulses load-descriptor. If the reloaded descriptor's end-of-list bit is clear while the channel's end-of-list flag is set, the saved data pointer (also driven on desc_ptr) moves to that descriptor's next pointer, and the block pulses start and clears the flag. One cycle later, 0x5C takes the buffer pointer of the descriptor now selected and 0x00 takes the saved data pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address (channel index, then register window) |
| bus_size | input | 2 | Access size code; 2 = 32-bit word |
| bus_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response strobe, one cycle after a request |
| resp_err | output | 1 | Error response |
| resp_rdata | output | 32 | Read data |
| src_id | input | NUM_CH*SW | Per-channel stream-command source field shown in status |
| desc_ptr | output | NUM_CH*32 | Per-channel saved data pointer, the address of the current descriptor |
| desc_eol_in | input | NUM_CH | End-of-list bit of the descriptor at desc_ptr |
| desc_next_in | input | NUM_CH*32 | Next pointer of the descriptor at desc_ptr |
| desc_buf_in | input | NUM_CH*32 | Buffer pointer of the descriptor at desc_ptr |
| ctx_data_in | input | NUM_CH*32 | Context saved-data word |
| ctx_buf_in | input | NUM_CH*32 | Context saved-buffer word |
| eol_hit | input | NUM_CH | Engine end-of-list pulse |
| irq_set | input | NUM_CH*IW | Engine interrupt cause pulses |
| irq | output | NUM_CH | Per-channel interrupt line |
| ld_desc_req | output | NUM_CH | Load-descriptor request pulse |
| ld_ctx_req | output | NUM_CH | Load-context request pulse |
| start_req | output | NUM_CH | Start request pulse |

## Verification
A wrong state bit shows up on the next status read as a code that is not one of 1, 2 or 4, or as a continue command that ignores its gate. Either way it appears at the ports within one bus transaction. A wrong raw or mask bit shows up on the interrupt line in the cycle after the causing event, and in the masked register on the next read. A bad continue decision appears in the same response cycle as a missing or extra load or start pulse. One cycle later it appears as a wrong saved data pointer or buffer pointer.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
package dma_chan_pkg;
   typedef enum logic [2:0] {
      ST_RST  = 3'b001,
      ST_STOP = 3'b010,
      ST_RUN  = 3'b100
   } ch_state_e;

   localparam logic [5:0] IX_DATA   = 6'h00;
   localparam logic [5:0] IX_SDATA  = 6'h16;
   localparam logic [5:0] IX_SBUF   = 6'h17;
   localparam logic [5:0] IX_GROUP  = 6'h18;
   localparam logic [5:0] IX_GDOWN  = 6'h1F;
   localparam logic [5:0] IX_CMD    = 6'h20;
   localparam logic [5:0] IX_CFG    = 6'h21;
   localparam logic [5:0] IX_STAT   = 6'h22;
   localparam logic [5:0] IX_MASK   = 6'h23;
   localparam logic [5:0] IX_ACK    = 6'h24;
   localparam logic [5:0] IX_RAW    = 6'h25;
   localparam logic [5:0] IX_MASKED = 6'h26;
   localparam logic [5:0] IX_SCMD   = 6'h27;

   localparam logic [9:0] SC_LD_DESC = 10'h140;
   localparam int         SC_BURST_BIT = 5;
   localparam int         SC_LD_CTX_BIT = 9;

   localparam logic [1:0] SIZE_WORD = 2'd2;
endpackage

// File: rtl/dma_chan_irq.sv
`timescale 1ns/1ps
module dma_chan_irq #(
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] set_i,
   input  logic          mask_we,
   input  logic          ack_we,
   input  logic [IW-1:0] wdata,
   output logic [IW-1:0] raw_o,
   output logic [IW-1:0] mask_o,
   output logic          irq_o
);
   logic [IW-1:0] raw_q, mask_q;
   logic [IW-1:0] clr;

   assign clr = ack_we ? wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_q  <= '0;
         mask_q <= '0;
      end else begin
         raw_q <= (raw_q & ~clr) | set_i;
         if (mask_we) mask_q <= wdata;
      end
   end

   assign raw_o  = raw_q;
   assign mask_o = mask_q;
   assign irq_o  = |(raw_q & mask_q);

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && set_i == '0) |=> ((raw_q & $past(wdata)) == '0)); // R6
   AST_SET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((raw_q & $past(set_i)) == $past(set_i))); // R6
   AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq_o); // R7
endmodule

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
module dma_chan_regs
   import dma_chan_pkg::*;
#(
   parameter int IW = 4,
   parameter int SW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [5:0]    ix,
   input  logic [31:0]   wdata,
   output logic [31:0]   rdata,
   input  logic [SW-1:0] src_i,
   output logic [31:0]   desc_ptr_o,
   input  logic          desc_eol_i,
   input  logic [31:0]   desc_next_i,
   input  logic [31:0]   desc_buf_i,
   input  logic [31:0]   ctx_data_i,
   input  logic [31:0]   ctx_buf_i,
   input  logic          eol_hit_i,
   input  logic [IW-1:0] irq_set_i,
   output logic          irq_o,
   output logic          ld_desc_o,
   output logic          ld_ctx_o,
   output logic          start_o
);
   ch_state_e   state_q;
   logic [31:0] data_q, sdata_q, sbuf_q, group_q, gdown_q, cmd_q, cfg_q, scmd_q;
   logic        eol_q, cur_eol_q, ph2_q;
   logic        ld_desc_q, ld_ctx_q, start_q;
   logic [IW-1:0] raw, mask;
   logic        cont_ok;

   assign cont_ok = cfg_q[0] && !cfg_q[1] && (state_q == ST_RUN) && cur_eol_q;

   dma_chan_irq #(.IW(IW)) u_irq (
      .clk(clk), .rst_n(rst_n), .set_i(irq_set_i),
      .mask_we(wr_en && ix == IX_MASK), .ack_we(wr_en && ix == IX_ACK),
      .wdata(wdata[IW-1:0]), .raw_o(raw), .mask_o(mask), .irq_o(irq_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_RST;
         {data_q, sdata_q, sbuf_q, group_q} <= '0;
         {gdown_q, cmd_q, cfg_q, scmd_q}    <= '0;
         {eol_q, cur_eol_q, ph2_q}          <= '0;
         {ld_desc_q, ld_ctx_q, start_q}     <= '0;
      end else begin
         ld_desc_q <= 1'b0;
         ld_ctx_q  <= 1'b0;
         start_q   <= 1'b0;
         ph2_q     <= 1'b0;
         if (eol_hit_i) eol_q <= 1'b1;
         if (ph2_q) begin
            sbuf_q    <= desc_buf_i;
            cur_eol_q <= desc_eol_i;
            data_q    <= sdata_q;
         end
         if (wr_en) begin
            case (ix)
               IX_DATA:  data_q  <= wdata;
               IX_SDATA: sdata_q <= wdata;
               IX_SBUF:  sbuf_q  <= wdata;
               IX_GROUP: group_q <= wdata;
               IX_GDOWN: gdown_q <= wdata;
               IX_CFG: begin
                  cfg_q <= wdata;
                  if (!wdata[0])     state_q <= ST_RST;
                  else if (wdata[1]) state_q <= ST_STOP;
               end
               IX_CMD: begin
                  cmd_q <= wdata;
                  if (cont_ok) begin
                     cur_eol_q <= desc_eol_i;
                     data_q    <= sdata_q;
                     ld_desc_q <= 1'b1;
                     ph2_q     <= 1'b1;
                     if (!desc_eol_i && eol_q) begin
                        sdata_q <= desc_next_i;
                        state_q <= ST_RUN;
                        eol_q   <= 1'b0;
                        start_q <= 1'b1;
                     end
                  end
               end
               IX_SCMD: begin
                  scmd_q <= wdata;
                  if (|(wdata[9:0] & SC_LD_DESC)) begin
                     data_q    <= sdata_q;
                     cur_eol_q <= desc_eol_i;
                     ld_desc_q <= 1'b1;
                     if (wdata[SC_BURST_BIT]) begin
                        state_q <= ST_RUN;
                        eol_q   <= 1'b0;
                        start_q <= 1'b1;
                     end
                  end
                  if (wdata[SC_LD_CTX_BIT]) begin
                     sdata_q  <= ctx_data_i;
                     sbuf_q   <= ctx_buf_i;
                     ld_ctx_q <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (ix)
         IX_DATA:   rdata = data_q;
         IX_SDATA:  rdata = sdata_q;
         IX_SBUF:   rdata = sbuf_q;
         IX_GROUP:  rdata = group_q;
         IX_GDOWN:  rdata = gdown_q;
         IX_CMD:    rdata = cmd_q;
         IX_CFG:    rdata = cfg_q;
         IX_STAT:   rdata = {{(24-SW){1'b0}}, src_i, 2'b00, eol_q, 2'b00, state_q};
         IX_MASK:   rdata = {{(32-IW){1'b0}}, mask};
         IX_RAW:    rdata = {{(32-IW){1'b0}}, raw};
         IX_MASKED: rdata = {{(32-IW){1'b0}}, raw & mask};
         IX_SCMD:   rdata = scmd_q;
         default:   rdata = '0;
      endcase
   end

   assign desc_ptr_o = sdata_q;
   assign ld_desc_o  = ld_desc_q;
   assign ld_ctx_o   = ld_ctx_q;
   assign start_o    = start_q;

   AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(state_q)); // R1
   AST_CFG_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ix == IX_CFG && !wdata[0]) |=> (state_q == ST_RST)); // R4
   AST_CFG_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ix == IX_CFG && wdata[1:0] == 2'b11) |=> (state_q == ST_STOP)); // R4
   AST_START_CLEARS_EOL: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> (state_q == ST_RUN && !eol_q)); // R8
   AST_CONT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ix == IX_CMD && state_q != ST_RUN) |=> (!ld_desc_q && $stable(sdata_q))); // R11
   AST_IDLE_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg_q)); // R2
endmodule

// File: rtl/dma_chan_ctrl.sv
`timescale 1ns/1ps
module dma_chan_ctrl
   import dma_chan_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int IW     = 4,
   parameter int SW     = 8,
   localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int AW    = 13 + CHW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_valid,
   input  logic                 bus_write,
   input  logic [AW-1:0]        bus_addr,
   input  logic [1:0]           bus_size,
   input  logic [31:0]          bus_wdata,
   output logic                 resp_valid,
   output logic                 resp_err,
   output logic [31:0]          resp_rdata,
   input  logic [NUM_CH*SW-1:0] src_id,
   output logic [NUM_CH*32-1:0] desc_ptr,
   input  logic [NUM_CH-1:0]    desc_eol_in,
   input  logic [NUM_CH*32-1:0] desc_next_in,
   input  logic [NUM_CH*32-1:0] desc_buf_in,
   input  logic [NUM_CH*32-1:0] ctx_data_in,
   input  logic [NUM_CH*32-1:0] ctx_buf_in,
   input  logic [NUM_CH-1:0]    eol_hit,
   input  logic [NUM_CH*IW-1:0] irq_set,
   output logic [NUM_CH-1:0]    irq,
   output logic [NUM_CH-1:0]    ld_desc_req,
   output logic [NUM_CH-1:0]    ld_ctx_req,
   output logic [NUM_CH-1:0]    start_req
);
   if (NUM_CH < 1 || NUM_CH > 64) begin : g_bad_ch
      $error("NUM_CH must be in 1..64");
   end
   if (IW < 1 || IW > 31) begin : g_bad_iw
      $error("IW must be in 1..31");
   end
   if (SW < 1 || SW > 23) begin : g_bad_sw
      $error("SW must be in 1..23");
   end

   logic [CHW-1:0] ch_sel;
   logic [5:0]     ix;
   logic           ok;
   logic [31:0]    rd_arr [NUM_CH];
   logic [31:0]    rd_sel;
   logic           unused_addr_bits;

   assign ch_sel = bus_addr[AW-1:13];
   assign ix     = bus_addr[7:2];
   assign ok     = (bus_size == SIZE_WORD) && ({1'b0, ch_sel} < (CHW+1)'(NUM_CH));
   assign unused_addr_bits = ^{bus_addr[12:8], bus_addr[1:0]};

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dma_chan_regs #(.IW(IW), .SW(SW)) u_ch (
         .clk(clk), .rst_n(rst_n),
         .wr_en(bus_valid && bus_write && ok && ch_sel == CHW'(c)),
         .ix(ix), .wdata(bus_wdata), .rdata(rd_arr[c]),
         .src_i(src_id[c*SW +: SW]),
         .desc_ptr_o(desc_ptr[c*32 +: 32]),
         .desc_eol_i(desc_eol_in[c]),
         .desc_next_i(desc_next_in[c*32 +: 32]),
         .desc_buf_i(desc_buf_in[c*32 +: 32]),
         .ctx_data_i(ctx_data_in[c*32 +: 32]),
         .ctx_buf_i(ctx_buf_in[c*32 +: 32]),
         .eol_hit_i(eol_hit[c]),
         .irq_set_i(irq_set[c*IW +: IW]),
         .irq_o(irq[c]),
         .ld_desc_o(ld_desc_req[c]),
         .ld_ctx_o(ld_ctx_req[c]),
         .start_o(start_req[c])
      );
   end

   always_comb begin
      rd_sel = '0;
      for (int c = 0; c < NUM_CH; c++)
         if (ch_sel == CHW'(c)) rd_sel = rd_arr[c];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_err   <= 1'b0;
         resp_rdata <= '0;
      end else begin
         resp_valid <= bus_valid;
         resp_err   <= bus_valid && !ok;
         resp_rdata <= (bus_valid && !bus_write && ok) ? rd_sel : '0;
      end
   end

   AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |=> resp_valid); // R3
   AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_size != SIZE_WORD) |=> (resp_err && resp_rdata == '0)); // R3
endmodule

// File: tb/tb_dma_chan_ctrl.sv
`timescale 1ns/1ps
module tb_dma_chan_ctrl;
   localparam int NCH = 3;
   localparam int IW  = 4;
   localparam int SW  = 8;
   localparam int AW  = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_valid = 1'b0, bus_write = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [1:0] bus_size = 2'd2;
   logic [31:0] bus_wdata = '0;
   logic resp_valid, resp_err;
   logic [31:0] resp_rdata;
   logic [NCH*SW-1:0] src_id = {8'h3C, 8'h5A, 8'hA5};
   logic [NCH*32-1:0] desc_ptr, desc_next_in, desc_buf_in;
   logic [NCH-1:0] desc_eol_in;
   logic [NCH*32-1:0] ctx_data_in = {32'h2222_0058, 32'h1111_0058, 32'h0000_0058};
   logic [NCH*32-1:0] ctx_buf_in  = {32'h2222_005C, 32'h1111_005C, 32'h0000_005C};
   logic [NCH-1:0] eol_hit = '0;
   logic [NCH*IW-1:0] irq_set = '0;
   logic [NCH-1:0] irq, ld_desc_req, ld_ctx_req, start_req;

   logic [15:0] eol_tbl = 16'hFFFF;
   int n_chk = 0, n_err = 0;
   bit done = 0;
   logic [31:0] r_data;
   logic r_err;
   logic [NCH-1:0] c_ldd, c_ldc, c_st;
   logic [IW-1:0] m_raw [NCH];
   logic [IW-1:0] m_mask [NCH];

   always #4 clk = ~clk;

   function automatic logic [31:0] nxt(input logic [31:0] p);
      return p + 32'h44;
   endfunction
   function automatic logic [31:0] bufv(input logic [31:0] p);
      return {p[15:0], 16'hB0F0};
   endfunction

   always_comb begin
      for (int c = 0; c < NCH; c++) begin
         desc_eol_in[c]         = eol_tbl[desc_ptr[c*32+2 +: 4]];
         desc_next_in[c*32 +: 32] = nxt(desc_ptr[c*32 +: 32]);
         desc_buf_in[c*32 +: 32]  = bufv(desc_ptr[c*32 +: 32]);
      end
   end

   dma_chan_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
      .src_id(src_id), .desc_ptr(desc_ptr), .desc_eol_in(desc_eol_in),
      .desc_next_in(desc_next_in), .desc_buf_in(desc_buf_in),
      .ctx_data_in(ctx_data_in), .ctx_buf_in(ctx_buf_in), .eol_hit(eol_hit),
      .irq_set(irq_set), .irq(irq), .ld_desc_req(ld_desc_req),
      .ld_ctx_req(ld_ctx_req), .start_req(start_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] adr(input int ch, input logic [7:0] off);
      return AW'(ch * 32'h2000 + off);
   endfunction

   task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [1:0] sz,
                       input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      r_data = resp_rdata; r_err = resp_err;
      c_ldd = ld_desc_req; c_ldc = ld_ctx_req; c_st = start_req;
      check("R3 resp_valid", {31'b0, resp_valid}, 32'd1);
   endtask

   task automatic wr(input int ch, input logic [7:0] off, input logic [31:0] d);
      xfer(1'b1, adr(ch, off), 2'd2, d);
   endtask
   task automatic rd(input int ch, input logic [7:0] off);
      xfer(1'b0, adr(ch, off), 2'd2, 32'h0);
   endtask
   function automatic logic [31:0] stat(input int ch, input logic [2:0] st, input bit e);
      return {16'h0, src_id[ch*SW +: SW], 2'b00, e, 2'b00, st};
   endfunction

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 irq", {29'b0, irq}, 32'd0);
      check("R1 pulses", {23'b0, ld_desc_req, ld_ctx_req, start_req}, 32'd0);
      for (int c = 0; c < NCH; c++) begin
         rd(c, 8'h88); check("R1 R5 status", r_data, stat(c, 3'd1, 1'b0));
         rd(c, 8'h84); check("R1 cfg", r_data, 32'd0);
         rd(c, 8'h94); check("R1 raw", r_data, 32'd0);
         m_raw[c] = '0; m_mask[c] = '0;
      end
      // R2 readback, aliasing of channels, ack reads zero, unlisted offsets
      wr(0, 8'h60, 32'hCAFE_0060); wr(1, 8'h60, 32'h0BAD_1060);
      rd(0, 8'h60); check("R2 group ch0", r_data, 32'hCAFE_0060);
      rd(1, 8'h60); check("R2 group ch1", r_data, 32'h0BAD_1060);
      wr(2, 8'h7C, 32'h1234_5678); rd(2, 8'h7C); check("R2 gdown", r_data, 32'h1234_5678);
      wr(2, 8'h9C, 32'h0000_0001); rd(2, 8'h9C); check("R2 scmd", r_data, 32'h0000_0001);
      wr(0, 8'h40, 32'hFFFF_FFFF); rd(0, 8'h40); check("R2 unlisted", r_data, 32'd0);
      wr(0, 8'h94, 32'hF); rd(0, 8'h94); check("R2 raw not writable", r_data, 32'd0);
      wr(0, 8'h90, 32'hF); rd(0, 8'h90); check("R2 ack reads 0", r_data, 32'd0);
      // R3 bad size and bad channel
      xfer(1'b1, adr(1, 8'h84), 2'd1, 32'h3);
      check("R3 size err", {31'b0, r_err}, 32'd1);
      rd(1, 8'h84); check("R3 no write", r_data, 32'd0);
      xfer(1'b0, adr(3, 8'h60), 2'd2, 32'h0);
      check("R3 chan err", {31'b0, r_err}, 32'd1);
      check("R3 err data", r_data, 32'd0);
      // R4 state rules
      wr(0, 8'h84, 32'h3); rd(0, 8'h88); check("R4 stop", r_data, stat(0, 3'd2, 1'b0));
      wr(0, 8'h84, 32'h1); rd(0, 8'h88); check("R4 unchanged", r_data, stat(0, 3'd2, 1'b0));
      wr(0, 8'h84, 32'h2); rd(0, 8'h88); check("R4 reset wins", r_data, stat(0, 3'd1, 1'b0));
      // R9 context load
      wr(2, 8'h9C, 32'h200);
      check("R9 ld_ctx pulse", {29'b0, c_ldc}, 32'b100);
      rd(2, 8'h58); check("R9 sdata", r_data, 32'h2222_0058);
      rd(2, 8'h5C); check("R9 sbuf", r_data, 32'h2222_005C);
      // R8 load descriptor + burst start on ch1
      wr(1, 8'h84, 32'h1);
      wr(1, 8'h58, 32'h0000_1000);
      wr(1, 8'h9C, 32'h160);
      check("R8 ld_desc", {29'b0, c_ldd}, 32'b010);
      check("R8 start", {29'b0, c_st}, 32'b010);
      rd(1, 8'h00); check("R8 data reg", r_data, 32'h0000_1000);
      rd(1, 8'h88); check("R8 R5 running", r_data, stat(1, 3'd4, 1'b0));
      // R11 gate: stopped channel ignores continue
      wr(1, 8'h5C, 32'h0000_DEAD);
      wr(1, 8'h84, 32'h3);
      wr(1, 8'h80, 32'h1);
      check("R11 no ld_desc", {29'b0, c_ldd}, 32'd0);
      rd(1, 8'h5C); check("R11 sbuf kept", r_data, 32'h0000_DEAD);
      wr(1, 8'h84, 32'h1);
      wr(1, 8'h9C, 32'h060);
      check("R8 bit6 ld_desc", {29'b0, c_ldd}, 32'b010);
      // R12 qualifying continue without advance
      wr(1, 8'h80, 32'h1);
      check("R12 reload pulse", {29'b0, c_ldd}, 32'b010);
      check("R12 no start", {29'b0, c_st}, 32'd0);
      rd(1, 8'h5C); check("R12 sbuf cur", r_data, bufv(32'h1000));
      rd(1, 8'h58); check("R12 sdata kept", r_data, 32'h1000);
      // R10 eol
      @(negedge clk); eol_hit = 3'b010; @(negedge clk); eol_hit = '0;
      rd(1, 8'h88); check("R10 R5 eol", r_data, stat(1, 3'd4, 1'b1));
      wr(1, 8'h80, 32'h1);
      check("R12 eol still set no start", {29'b0, c_st}, 32'd0);
      rd(1, 8'h88); check("R12 still eol", r_data, stat(1, 3'd4, 1'b1));
      // R12 advance after software clears descriptor eol
      eol_tbl[0] = 1'b0;
      wr(1, 8'h80, 32'h1);
      check("R12 start", {29'b0, c_st}, 32'b010);
      check("R12 ptr out", desc_ptr[63:32], 32'h1044);
      rd(1, 8'h58); check("R12 sdata next", r_data, 32'h1044);
      rd(1, 8'h5C); check("R12 sbuf next", r_data, bufv(32'h1044));
      rd(1, 8'h00); check("R12 data next", r_data, 32'h1044);
      rd(1, 8'h88); check("R12 eol cleared", r_data, stat(1, 3'd4, 1'b0));
      // R6 set wins over ack in the same cycle
      @(negedge clk);
      irq_set[3:0] = 4'h4;
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = adr(0, 8'h90); bus_size = 2'd2;
      bus_wdata = 32'h4;
      @(negedge clk);
      irq_set = '0; bus_valid = 1'b0; bus_write = 1'b0;
      m_raw[0] = 4'h4;
      rd(0, 8'h94); check("R6 set wins", r_data, 32'h4);
      // R6 R7 random mix
      for (int i = 0; i < 200; i++) begin
         int c;
         int op;
         logic [IW-1:0] v;
         c = $urandom_range(0, NCH - 1);
         op = $urandom_range(0, 2);
         v = IW'($urandom);
         if (op == 0) begin
            @(negedge clk); irq_set[c*IW +: IW] = v; @(negedge clk); irq_set = '0;
            m_raw[c] = m_raw[c] | v;
         end else if (op == 1) begin
            wr(c, 8'h8C, {28'b0, v}); m_mask[c] = v;
         end else begin
            wr(c, 8'h90, {28'b0, v}); m_raw[c] = m_raw[c] & ~v;
         end
         check("R7 irq line", {31'b0, irq[c]}, {31'b0, |(m_raw[c] & m_mask[c])});
         rd(c, 8'h94); check("R6 raw", r_data, {28'b0, m_raw[c]});
         rd(c, 8'h98); check("R7 masked", r_data, {28'b0, m_raw[c] & m_mask[c]});
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule